// File: doc/BRIEF.md
# GPIO interrupt controller

A byte-addressed GPIO block with three 8-bit ports (A, B and F). Each port holds an output value, a per-pin output enable and a set of interrupt controls: detection mode (level or edge), active polarity, per-pin enable, a per-pin debounce select and a write-one-to-clear acknowledge. A read-only status register shows which enabled pins are currently requesting. Ports A and B merge into one shared interrupt line. Each port F pin has an interrupt line of its own.

Every pin input passes through a two-flop synchronizer. A pin with its debounce bit set then passes through a filter that waits out glitches. The filter is a two-state machine per pin. In `DB_STEADY` it holds its output. It moves to `DB_SETTLE` when the synchronized input differs from the output. From `DB_SETTLE` it returns to `DB_STEADY` without a change when the input goes back to the held value (glitch rejected). It also returns to `DB_STEADY`, taking the new value, after the input has differed for `DB_TICKS` consecutive sample ticks. A divider produces one sample tick every `TICK_DIV` clocks.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0. All output enables, `irq_ab` and `irq_f` are 0.
- R2: `pin_oe_x` equals the port's direction register, and `pin_out_x` equals its data register. A read of the data register returns the data bit for pins whose direction bit is 1 and the synchronized pin for pins whose direction bit is 0.
- R3: In level mode (mode bit 0), a status bit is 1 while the pin is enabled and its input equals the polarity bit (0 = low, 1 = high). It falls again when the input leaves that level.
- R4: In edge mode (mode bit 1), a transition of the input to the polarity level (polarity 1 = rising, 0 = falling) latches an event. The status bit then stays 1 after the input returns, until the event is cleared. A transition away from the polarity level latches nothing.
- R5: A write to the acknowledge register clears the latched event of each pin written as 1. Bits written as 0 are left unchanged. The acknowledge register always reads 0. Clearing takes priority over a new event in the same cycle.
- R6: A pin whose enable bit is 0 shows status 0 and never latches an edge event. Setting the enable bit later does not reveal an edge that occurred while the pin was disabled.
- R7: Any write to a port's mode or polarity register clears all latched edge events of that port.
- R8: `irq_ab` is the OR of all status bits of ports A and B. `irq_f[i]` equals status bit i of port F.
- R9: When a pin's debounce bit is 1, a new input level is seen by detection only after it has differed from the filter output for `DB_TICKS` consecutive sample ticks. A shorter pulse has no effect.
- R10: The byte addresses, in the order A, B, F, are:
  - data: 0x00, 0x04, 0x30
  - direction: 0x10, 0x14, 0x34
  - mode: 0x90, 0xAC, 0x4C
  - polarity: 0x94, 0xB0, 0x50
  - acknowledge: 0x98, 0xB4, 0x54
  - enable: 0x9C, 0xB8, 0x58
  - status: 0xA0, 0xBC, 0x5C
  - debounce: 0xA8, 0xC4, 0x64

  The status register is read-only. Unmapped addresses read 0.
- R11: With debounce off, a level-mode status change appears exactly two clock edges after the pin changes, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in_a | input | 8 | Port A pin inputs |
| pin_in_b | input | 8 | Port B pin inputs |
| pin_in_f | input | 8 | Port F pin inputs |
| pin_out_a | output | 8 | Port A output values |
| pin_out_b | output | 8 | Port B output values |
| pin_out_f | output | 8 | Port F output values |
| pin_oe_a | output | 8 | Port A output enables |
| pin_oe_b | output | 8 | Port B output enables |
| pin_oe_f | output | 8 | Port F output enables |
| irq_ab | output | 1 | Shared interrupt of ports A and B |
| irq_f | output | 8 | Per-pin interrupts of port F |

## Verification
The bench builds the block with `TICK_DIV = 4` and `DB_TICKS = 4`. This puts a full debounce window at about twenty clocks. A six-clock glitch can then be shown to be rejected, and a held level to be accepted, within a short directed test. With these small values, the exact two-edge synchronizer latency and the one-cycle visibility of register writes can be sampled cycle by cycle, with the debounce path taking part in the same run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_AW   = 8;
    localparam int BUS_DW   = 8;
    localparam int PORT_CNT = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_MODE,
        SEL_POL,
        SEL_ACK,
        SEL_EN,
        SEL_STAT,
        SEL_DB
    } reg_sel_e;

    // Port order inside each table: A, B, F
    localparam logic [BUS_AW-1:0] A_DATA [PORT_CNT] = '{8'h00, 8'h04, 8'h30};
    localparam logic [BUS_AW-1:0] A_DIR  [PORT_CNT] = '{8'h10, 8'h14, 8'h34};
    localparam logic [BUS_AW-1:0] A_MODE [PORT_CNT] = '{8'h90, 8'hAC, 8'h4C};
    localparam logic [BUS_AW-1:0] A_POL  [PORT_CNT] = '{8'h94, 8'hB0, 8'h50};
    localparam logic [BUS_AW-1:0] A_ACK  [PORT_CNT] = '{8'h98, 8'hB4, 8'h54};
    localparam logic [BUS_AW-1:0] A_EN   [PORT_CNT] = '{8'h9C, 8'hB8, 8'h58};
    localparam logic [BUS_AW-1:0] A_STAT [PORT_CNT] = '{8'hA0, 8'hBC, 8'h5C};
    localparam logic [BUS_AW-1:0] A_DB   [PORT_CNT] = '{8'hA8, 8'hC4, 8'h64};

    function automatic reg_sel_e decode_reg(input logic [BUS_AW-1:0] a, input int p);
        if (a == A_DATA[p]) return SEL_DATA;
        if (a == A_DIR[p])  return SEL_DIR;
        if (a == A_MODE[p]) return SEL_MODE;
        if (a == A_POL[p])  return SEL_POL;
        if (a == A_ACK[p])  return SEL_ACK;
        if (a == A_EN[p])   return SEL_EN;
        if (a == A_STAT[p]) return SEL_STAT;
        if (a == A_DB[p])   return SEL_DB;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    localparam int CW = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;

    typedef enum logic {
        DB_STEADY,
        DB_SETTLE
    } db_state_e;

    db_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          clean_q, clean_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            clean_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            clean_q <= clean_d;
        end
    end

    // Transitions and held output
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        clean_d = clean_q;
        unique case (state_q)
            DB_STEADY: begin
                if (raw != clean_q) begin
                    state_d = DB_SETTLE;
                    cnt_d   = '0;
                end
            end
            DB_SETTLE: begin
                if (raw == clean_q) begin
                    state_d = DB_STEADY;
                end else if (tick) begin
                    if (cnt_q == CW'(STABLE_TICKS - 1)) begin
                        clean_d = raw;
                        state_d = DB_STEADY;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = DB_STEADY;
        endcase
    end

    assign clean = clean_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_irq_pkg::*;
#(
    parameter int W        = BUS_DW,
    parameter int DB_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  reg_sel_e     sel,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] stat
);
    logic [W-1:0] data_q, dir_q, mode_q, pol_q, en_q, db_q;
    logic [W-1:0] sync1_q, sync2_q, prev_q, edge_q;
    logic [W-1:0] db_out, filt, level_hit, edge_hit, clr, edge_d;

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            gpio_debounce #(.STABLE_TICKS(DB_TICKS)) u_db (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .raw   (sync2_q[i]),
                .clean (db_out[i])
            );
        end
    endgenerate

    assign filt      = (db_q & db_out) | (~db_q & sync2_q);
    assign level_hit = ~(filt ^ pol_q);
    assign edge_hit  = (filt ^ prev_q) & level_hit;

    always_comb begin
        clr = '0;
        if (we && sel == SEL_ACK)
            clr = wdata;
        if (we && (sel == SEL_MODE || sel == SEL_POL))
            clr = '1;
    end

    assign edge_d = (edge_q | (edge_hit & en_q & mode_q)) & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            mode_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
            db_q    <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
            edge_q  <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            prev_q  <= filt;
            edge_q  <= edge_d;
            if (we) begin
                case (sel)
                    SEL_DATA: data_q <= wdata;
                    SEL_DIR:  dir_q  <= wdata;
                    SEL_MODE: mode_q <= wdata;
                    SEL_POL:  pol_q  <= wdata;
                    SEL_EN:   en_q   <= wdata;
                    SEL_DB:   db_q   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign stat    = en_q & ((mode_q & edge_q) | (~mode_q & level_hit));
    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    always_comb begin
        case (sel)
            SEL_DATA: rdata = (dir_q & data_q) | (~dir_q & sync2_q);
            SEL_DIR:  rdata = dir_q;
            SEL_MODE: rdata = mode_q;
            SEL_POL:  rdata = pol_q;
            SEL_EN:   rdata = en_q;
            SEL_STAT: rdata = stat;
            SEL_DB:   rdata = db_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int TICK_DIV = 256,
    parameter int DB_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [BUS_DW-1:0] pin_in_a,
    input  logic [BUS_DW-1:0] pin_in_b,
    input  logic [BUS_DW-1:0] pin_in_f,
    output logic [BUS_DW-1:0] pin_out_a,
    output logic [BUS_DW-1:0] pin_out_b,
    output logic [BUS_DW-1:0] pin_out_f,
    output logic [BUS_DW-1:0] pin_oe_a,
    output logic [BUS_DW-1:0] pin_oe_b,
    output logic [BUS_DW-1:0] pin_oe_f,
    output logic              irq_ab,
    output logic [BUS_DW-1:0] irq_f
);
    logic              tick;
    logic [BUS_DW-1:0] pin_in_w  [PORT_CNT];
    logic [BUS_DW-1:0] pin_out_w [PORT_CNT];
    logic [BUS_DW-1:0] pin_oe_w  [PORT_CNT];
    logic [BUS_DW-1:0] stat_w    [PORT_CNT];
    logic [BUS_DW-1:0] rdata_w   [PORT_CNT];

    gpio_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign pin_in_w[0] = pin_in_a;
    assign pin_in_w[1] = pin_in_b;
    assign pin_in_w[2] = pin_in_f;

    generate
        for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
            reg_sel_e sel;
            assign sel = decode_reg(bus_addr, p);
            gpio_port #(.W(BUS_DW), .DB_TICKS(DB_TICKS)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .sel     (sel),
                .we      (bus_we),
                .wdata   (bus_wdata),
                .rdata   (rdata_w[p]),
                .pin_in  (pin_in_w[p]),
                .pin_out (pin_out_w[p]),
                .pin_oe  (pin_oe_w[p]),
                .stat    (stat_w[p])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < PORT_CNT; p++)
            bus_rdata = bus_rdata | rdata_w[p];
    end

    assign pin_out_a = pin_out_w[0];
    assign pin_out_b = pin_out_w[1];
    assign pin_out_f = pin_out_w[2];
    assign pin_oe_a  = pin_oe_w[0];
    assign pin_oe_b  = pin_oe_w[1];
    assign pin_oe_f  = pin_oe_w[2];

    assign irq_ab = (|stat_w[0]) | (|stat_w[1]);
    assign irq_f  = stat_w[2];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [BUS_DW-1:0] pin_out_f,
    input logic [BUS_DW-1:0] pin_oe_a,
    input logic [BUS_DW-1:0] pin_oe_b,
    input logic [BUS_DW-1:0] pin_oe_f,
    input logic              irq_ab,
    input logic [BUS_DW-1:0] irq_f
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_ab && irq_f == '0 && pin_oe_a == '0 && pin_oe_b == '0 && pin_oe_f == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR[0]) |=> pin_oe_a == $past(bus_wdata));

    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DATA[2]) |=> pin_out_f == $past(bus_wdata));

    p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ACK[0] || bus_addr == A_ACK[1] || bus_addr == A_ACK[2]) |-> bus_rdata == '0);

    p_disable_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN[2] && bus_wdata == '0) |=> irq_f == '0);

    p_mode_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MODE[2] && bus_wdata == '1) |=> irq_f == '0);

    p_stat_matches_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && bus_addr == A_STAT[2]) |-> bus_rdata == irq_f);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out_f (pin_out_f),
    .pin_oe_a  (pin_oe_a),
    .pin_oe_b  (pin_oe_b),
    .pin_oe_f  (pin_oe_f),
    .irq_ab    (irq_ab),
    .irq_f     (irq_f)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam logic [7:0] DATA_A = 8'h00, DIR_A = 8'h10, MODE_A = 8'h90, POL_A = 8'h94;
    localparam logic [7:0] EN_A = 8'h9C, STAT_A = 8'hA0, DB_A = 8'hA8, ACK_A = 8'h98;
    localparam logic [7:0] MODE_B = 8'hAC, POL_B = 8'hB0, EN_B = 8'hB8, STAT_B = 8'hBC, ACK_B = 8'hB4;
    localparam logic [7:0] MODE_F = 8'h4C, POL_F = 8'h50, ACK_F = 8'h54, EN_F = 8'h58, DB_F = 8'h64;
    localparam logic [7:0] NOWHERE = 8'hFF;

    // {write, addr, wdata/expected}
    localparam int NV = 18;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, DIR_A,  8'h0F}, {1'b0, DIR_A,  8'h0F},
        {1'b1, DATA_A, 8'hA5}, {1'b0, DATA_A, 8'h05},
        {1'b1, MODE_B, 8'h3C}, {1'b0, MODE_B, 8'h3C},
        {1'b1, POL_F,  8'h81}, {1'b0, POL_F,  8'h81},
        {1'b1, EN_B,   8'h55}, {1'b0, EN_B,   8'h55},
        {1'b1, DB_F,   8'h12}, {1'b0, DB_F,   8'h12},
        {1'b1, STAT_B, 8'hFF}, {1'b0, STAT_B, 8'h41},
        {1'b1, ACK_A,  8'hFF}, {1'b0, ACK_A,  8'h00},
        {1'b0, ACK_B,  8'h00}, {1'b0, 8'h08,  8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = NOWHERE;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in_a = 8'h00, pin_in_b = 8'h00, pin_in_f = 8'h00;
    logic [7:0] pin_out_a, pin_out_b, pin_out_f, pin_oe_a, pin_oe_b, pin_oe_f;
    logic       irq_ab;
    logic [7:0] irq_f;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.TICK_DIV(4), .DB_TICKS(4)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in_a(pin_in_a), .pin_in_b(pin_in_b), .pin_in_f(pin_in_f),
        .pin_out_a(pin_out_a), .pin_out_b(pin_out_b), .pin_out_f(pin_out_f),
        .pin_oe_a(pin_oe_a), .pin_oe_b(pin_oe_b), .pin_oe_f(pin_oe_f),
        .irq_ab(irq_ab), .irq_f(irq_f)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = NOWHERE;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = NOWHERE;
    endtask

    task automatic do_reset();
        pin_in_a = 8'h00; pin_in_b = 8'h00; pin_in_f = 8'h00;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int hits;
        do_reset();

        // R10 / R2 / R3 / R5: register map walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16]) begin
                wr(VEC[i][15:8], VEC[i][7:0]);
            end else begin
                rd(VEC[i][15:8], v);
                check("R10", $sformatf("read addr 0x%0h", VEC[i][15:8]), v, VEC[i][7:0]);
            end
        end
        check("R2", "pin_out_a after table", pin_out_a, 8'hA5);

        // R1: reset state
        do_reset();
        rd(DIR_A, v);  check("R1", "dir A", v, 0);
        rd(EN_B, v);   check("R1", "enable B", v, 0);
        rd(MODE_F, v); check("R1", "mode F", v, 0);
        check("R1", "irq_ab", irq_ab, 0);
        check("R1", "irq_f", irq_f, 0);
        check("R1", "oe f", pin_oe_f, 0);

        // R2: mixed direction readback
        wr(DIR_A, 8'hF0); wr(DATA_A, 8'h30);
        pin_in_a = 8'h0A; step(3);
        rd(DATA_A, v); check("R2", "data A mixed read", v, 8'h3A);
        check("R2", "oe a", pin_oe_a, 8'hF0);
        check("R2", "out a", pin_out_a, 8'h30);

        // R3 / R11: level-high on A pin 2
        do_reset();
        wr(POL_A, 8'h04); wr(EN_A, 8'h04);
        check("R3", "level idle", irq_ab, 0);
        pin_in_a = 8'h04;
        step(1); check("R11", "after one edge", irq_ab, 0);
        step(1); check("R11", "after two edges", irq_ab, 1);
        rd(STAT_A, v); check("R3", "status A", v, 8'h04);
        check("R8", "irq_f untouched", irq_f, 0);
        pin_in_a = 8'h00; step(2);
        check("R3", "level released", irq_ab, 0);

        // R3 / R8: level-low on B pin 0 drives shared line
        do_reset();
        pin_in_b = 8'h01; step(3);
        wr(EN_B, 8'h01);
        check("R3", "low level inactive", irq_ab, 0);
        pin_in_b = 8'h00; step(3);
        check("R8", "B drives irq_ab", irq_ab, 1);

        // R4 / R5: rising edge on F pin 3
        do_reset();
        wr(MODE_F, 8'h08); wr(POL_F, 8'h08); wr(EN_F, 8'h08);
        pin_in_f = 8'h08; step(4);
        check("R4", "rising latched", irq_f, 8'h08);
        pin_in_f = 8'h00; step(4);
        check("R4", "held after return", irq_f, 8'h08);
        wr(ACK_F, 8'h00); check("R5", "ack zeros", irq_f, 8'h08);
        wr(ACK_F, 8'hF7); check("R5", "ack other bits", irq_f, 8'h08);
        wr(ACK_F, 8'h08); check("R5", "ack clears", irq_f, 8'h00);

        // R4: falling edge on F pin 5
        do_reset();
        pin_in_f = 8'h20;
        wr(MODE_F, 8'h20); wr(POL_F, 8'h00); wr(EN_F, 8'h20);
        step(4); check("R4", "no event yet", irq_f, 8'h00);
        pin_in_f = 8'h00; step(4);
        check("R4", "falling latched", irq_f, 8'h20);
        pin_in_f = 8'h20; step(4);
        check("R4", "rise ignored, held", irq_f, 8'h20);

        // R6: disabled pin never latches
        do_reset();
        wr(MODE_F, 8'h01); wr(POL_F, 8'h01);
        pin_in_f = 8'h01; step(4);
        check("R6", "disabled status", irq_f, 8'h00);
        wr(EN_F, 8'h01);
        check("R6", "no stale edge", irq_f, 8'h00);

        // R7: polarity write clears latch
        do_reset();
        wr(MODE_F, 8'h02); wr(POL_F, 8'h02); wr(EN_F, 8'h02);
        pin_in_f = 8'h02; step(4);
        check("R7", "latched before", irq_f, 8'h02);
        wr(POL_F, 8'h02);
        check("R7", "pol write clears", irq_f, 8'h00);

        // R9: debounce on A pin 6, level high
        do_reset();
        wr(DB_A, 8'h40); wr(POL_A, 8'h40); wr(EN_A, 8'h40);
        hits = 0;
        pin_in_a = 8'h40;
        for (int c = 0; c < 6; c++) begin step(1); hits += irq_ab; end
        pin_in_a = 8'h00;
        for (int c = 0; c < 20; c++) begin step(1); hits += irq_ab; end
        check("R9", "short pulse rejected", hits, 0);
        pin_in_a = 8'h40; step(10);
        check("R9", "not yet accepted", irq_ab, 0);
        step(40);
        check("R9", "held level accepted", irq_ab, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule